// File: doc/BRIEF.md
# Hardware Spinlock Bank

A bank of single-bit mutual-exclusion locks shared by several bus masters through one 32-bit register slave port. Each lock has its own word in the register space. Reading that word acquires the lock: the access returns the lock's previous state, and a free lock becomes taken at the clock edge that completes the read. A master that reads zero owns the lock. A master that reads one must retry later. Writing zero to the word frees the lock again.

A read-only status word at offset 0x000 reports how many locks the bank was built with. The lock count is a parameter and may be 32, 64, 128 or 256. The port accepts at most one access per cycle. An upstream arbiter puts concurrent requests into bus order, so an acquire and a release of the same lock can never collide. Read data is combinational and is valid in the same cycle as the request.

Top module: `hw_lock_bank`

## Requirements
- R1: A read of word offset 0x000 returns the count code log2(NUM_LOCKS)-4 in bits 31:28 and zero in all other bits. For the default of 32 locks this is 0x10000000.
- R2: After reset every lock is free, so the first read of any lock returns 0.
- R3: A read of a free lock returns 0 in the request cycle. The lock is taken from the next cycle on.
- R4: A read of a taken lock returns 1, meaning bit 0 set and bits 31:1 zero, and the lock stays taken.
- R5: A write of 0x00000000 to a lock word frees that lock.
- R6: A write of any non-zero value to a lock word leaves the state of every lock unchanged.
- R7: A write to the status word changes neither the status value nor any lock.
- R8: Offsets that map to neither the status word nor a lock read 0 and change no lock. This covers 0x004 to 0x0FC and everything from 0x100+4*NUM_LOCKS upward.
- R9: Lock i sits at byte offset 0x100+4*i. Address bits 1:0 are ignored. An access to one lock never changes another lock.
- R10: Accesses in consecutive cycles are applied strictly in order, and one access touches at most one lock. For example, acquire, release and acquire of the same lock in three back-to-back cycles return 0, then nothing, then 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address within the bank |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle of a read, zero otherwise |

## Verification
The assertions assume that the arbiter in front of the bank presents at most one access per cycle. They also assume that address, direction and write data are stable around the sampling edge, so an acquire and a release of the same lock reach the bank as two separate cycles. The stimulus drives one access per clock on the falling edge and holds it through the rising edge. It mixes random lock, status and unmapped offsets with random low address bits and both zero and non-zero write data. Directed sequences cover back-to-back acquire, release and acquire of one lock, and the boundary offsets on either side of the lock array.

// File: rtl/hw_lock_pkg.sv
package hw_lock_pkg;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned LOCK_BASE    = 'h100;
  localparam int unsigned CODE_LSB     = 28;
  localparam int unsigned CODE_W       = 4;

  function automatic logic [CODE_W-1:0] count_code(input int unsigned n);
    return CODE_W'($clog2(n) - 4);
  endfunction
endpackage

// File: rtl/hw_lock_decode.sv
module hw_lock_decode #(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned LOCK_W   = $clog2(NUM_LOCKS),
  localparam int unsigned WORD_W   = ADDR_W - 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic                 stat_hit_o,
  output logic                 lock_hit_o,
  output logic [LOCK_W-1:0]    lock_idx_o,
  output logic [NUM_LOCKS-1:0] acq_o,
  output logic [NUM_LOCKS-1:0] rel_o
);
  import hw_lock_pkg::*;

  localparam logic [WORD_W-1:0] BASE_WORD = WORD_W'(LOCK_BASE >> 2);
  localparam logic [WORD_W-1:0] END_WORD  = WORD_W'((LOCK_BASE >> 2) + NUM_LOCKS);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] off;

  assign word       = addr_i[ADDR_W-1:2];
  assign off        = word - BASE_WORD;
  assign stat_hit_o = req_i && (word == '0);
  assign lock_hit_o = req_i && (word >= BASE_WORD) && (word < END_WORD);
  assign lock_idx_o = off[LOCK_W-1:0];

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_sel
    logic sel;
    assign sel      = lock_hit_o && (lock_idx_o == LOCK_W'(i));
    assign acq_o[i] = sel && !we_i;
    assign rel_o[i] = sel && we_i && (wdata_i == '0);
  end

  // R10: a single access touches at most one lock
  assert_one_lock_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(acq_o | rel_o));
endmodule

// File: rtl/hw_lock_cells.sv
module hw_lock_cells #(
  parameter int unsigned NUM_LOCKS = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LOCKS-1:0] acq_i,
  input  logic [NUM_LOCKS-1:0] rel_i,
  output logic [NUM_LOCKS-1:0] taken_o
);
  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_cell
    logic taken_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       taken_q <= 1'b0;
      else if (acq_i[i]) taken_q <= 1'b1;
      else if (rel_i[i]) taken_q <= 1'b0;
    end
    assign taken_o[i] = taken_q;

    assert_acq_takes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acq_i[i] |=> taken_o[i]);
    assert_release_frees_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rel_i[i] |=> !taken_o[i]);
    assert_idle_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !acq_i[i] && !rel_i[i] |=> $stable(taken_o[i]));
  end
endmodule

// File: rtl/hw_lock_status.sv
module hw_lock_status #(
  parameter int unsigned NUM_LOCKS = 32
) (
  output logic [31:0] status_o
);
  import hw_lock_pkg::*;
  always_comb begin
    status_o = '0;
    status_o[CODE_LSB +: CODE_W] = count_code(NUM_LOCKS);
  end
endmodule

// File: rtl/hw_lock_bank.sv
module hw_lock_bank #(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned LOCK_W   = $clog2(NUM_LOCKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  logic                 stat_hit, lock_hit;
  logic [LOCK_W-1:0]    lock_idx;
  logic [NUM_LOCKS-1:0] acq, rel, taken;
  logic [31:0]          status;

  hw_lock_decode #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_decode (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .stat_hit_o(stat_hit), .lock_hit_o(lock_hit), .lock_idx_o(lock_idx),
    .acq_o(acq), .rel_o(rel)
  );

  hw_lock_cells #(.NUM_LOCKS(NUM_LOCKS)) u_cells (
    .clk_i, .rst_ni, .acq_i(acq), .rel_i(rel), .taken_o(taken)
  );

  hw_lock_status #(.NUM_LOCKS(NUM_LOCKS)) u_status (.status_o(status));

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (stat_hit)      rdata_o = status;
      else if (lock_hit) rdata_o = {31'b0, taken[lock_idx]};
    end
  end

  assert_status_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_hit && !we_i |-> rdata_o == status && rdata_o[27:0] == '0);
  assert_lock_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_hit && !we_i |-> rdata_o[31:1] == '0);
  assert_nonzero_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && wdata_i != '0 |=> $stable(taken));
  assert_status_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_hit && we_i |=> $stable(taken));
  assert_unmapped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !stat_hit && !lock_hit |-> rdata_o == '0 ##1 $stable(taken));
endmodule

// File: tb/hw_lock_bank_tb_top.sv
module hw_lock_bank_tb_top;
  localparam int N      = 32;
  localparam int ADDR_W = 12;
  localparam logic [31:0] STATUS_EXP = 32'h1000_0000;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int total = 0, bad = 0;
  bit done = 0;
  bit model [N];

  always #5 clk = ~clk;

  hw_lock_bank #(.NUM_LOCKS(N), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  function automatic int lock_of(input int a);
    int w = a >> 2;
    if (w >= 64 && w < 64 + N) return w - 64;
    return -1;
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    int l = lock_of(a);
    if ((a >> 2) == 0) return STATUS_EXP;
    if (l >= 0) return {31'b0, model[l]};
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit w, input int a, input logic [31:0] d, input string tag);
    int l = lock_of(a);
    @(negedge clk);
    req = 1; we = w; addr = ADDR_W'(a); wdata = d;
    #1;
    if (!w) check(tag, rdata, exp_read(a));
    if (l >= 0) begin
      if (!w) model[l] = 1;
      else if (d == 0) model[l] = 0;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req = 0; we = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    foreach (model[i]) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check("R2 reset rdata idle", rdata, 32'h0);

    acc(0, 'h000, 0, "R1 status");
    acc(0, 'h100, 0, "R2 lock0 free after reset");
    acc(0, 'h100, 0, "R4 lock0 taken reread");
    acc(0, 'h100 + 4*(N-1), 0, "R2 last lock free");
    acc(0, 'h104, 0, "R9 neighbour lock1 untouched");
    acc(1, 'h100, 32'h5, "R6 nonzero write");
    acc(0, 'h100, 0, "R6 lock0 still taken");
    acc(1, 'h100, 0, "R5 release");
    acc(0, 'h103, 0, "R9 low bits ignored reacquire");
    acc(1, 'h000, 0, "R7 status write");
    acc(0, 'h000, 0, "R7 status unchanged");
    acc(0, 'h108, 0, "R7 lock2 unaffected");
    acc(0, 'h004, 0, "R8 gap read");
    acc(0, 'h0FC, 0, "R8 gap top");
    acc(0, 'h100 + 4*N, 0, "R8 beyond count");
    acc(0, 'h100 + 4*N, 0, "R8 beyond count no effect");
    acc(1, 'h004, 0, "R8 gap write");
    acc(0, 'h108, 0, "R8 lock2 still taken");
    // back-to-back in consecutive cycles
    acc(0, 'h10C, 0, "R10 acquire");
    acc(1, 'h10C, 0, "R10 release");
    acc(0, 'h10C, 0, "R10 reacquire");
    acc(0, 'h10C, 0, "R10 held");
    idle();

    for (int k = 0; k < 4000; k++) begin
      int sel = $urandom_range(99);
      int a;
      bit w = $urandom_range(1);
      logic [31:0] d = ($urandom_range(9) < 7) ? 32'h0 : ($urandom() | 32'h1);
      string tag;
      if (sel < 80)      a = 'h100 + 4 * $urandom_range(N-1) + $urandom_range(3);
      else if (sel < 88) a = $urandom_range(3);
      else if (sel < 94) a = 4 + $urandom_range('hFB);
      else               a = 'h100 + 4*N + $urandom_range((1 << ADDR_W) - 'h100 - 4*N - 1);
      if (lock_of(a) >= 0) tag = model[lock_of(a)] ? "R4 random taken" : "R3 random free";
      else if ((a >> 2) == 0) tag = "R1 random status";
      else tag = "R8 random unmapped";
      acc(w, a, d, tag);
      if ($urandom_range(7) == 0) idle();
    end
    idle();

    for (int i = 0; i < N; i++) acc(0, 'h100 + 4*i, 0, "R9 final sweep");
    idle();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule